// File: doc/BRIEF.md
# Serial EEPROM Command Master

This block connects a host to an external serial EEPROM over three wires: an active-low select, a serial clock, and one bidirectional data line. The data line is split into an output, an output enable and an input at the pad. The host hands over one command at a time on a valid/ready port. A command carries a 3-bit command code, a 16-bit address and a byte count. Bytes to be written arrive on a valid/ready write stream. Bytes read back leave on a valid/ready read stream.

Back-pressure works on both streams at byte boundaries. When the write stream has no byte ready, or the read stream holds a byte the host has not taken, the block parks the serial clock high with select still low. It resumes once the handshake completes. A read byte stays on `rd_data` with `rd_valid` high until it is accepted.

The serial clock uses mode 3. It idles high. The master changes its output only on falling edges and samples the device on rising edges. Each half period lasts `HALF_CYC` system clocks. Every byte travels least significant bit first. After a data write or a status write, the block polls the status register until the device reports it is idle, and only then finishes the command.

Top module: `eeprom_ser_master`

## Requirements
- R1: `cmd_ready` is high exactly when the block is idle. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. From the next cycle `busy` is high and `cmd_ready` low until the command ends.
- R2: The command code selects the wire opcode: 0 read sends 0x03, 1 write sends 0x02, 2 write-enable sends 0x06, 3 write-disable sends 0x04, 4 status read sends 0x05, 5 status write sends 0x01.
- R3: Every byte on the data line goes least significant bit first. Read and write always send two address bytes after the opcode, low byte first.
- R4: Mode 3 signalling. The serial clock is high whenever select is high, and `ee_sd_o` changes only together with a falling serial clock edge.
- R5: While select is low, each clock level lasts at least `HALF_CYC` cycles. The first rising edge comes at least `CSS_CYC` cycles after select falls. Select stays high for at least `2*HALF_CYC` cycles between transfers.
- R6: `ee_sd_oe` is high for opcode, address and write-data bits and low for bits the device returns. It is also low whenever select is high.
- R7: A read returns `cmd_cnt+1` bytes from consecutive addresses on the read stream. `rd_data` is held stable and the serial clock is parked high while `rd_valid` waits for `rd_ready`.
- R8: A write takes `cmd_cnt+1` bytes from the write stream. The serial clock does not start a data byte until `wr_valid` is seen.
- R9: A status read returns one byte on the read stream, with bit 1 the write-enable latch and bit 0 write-in-progress. A status write sends one byte taken from the write stream.
- R10: After a write or status write, the block issues status-read transfers until bit 0 reads 0. None of these polls appears on the read stream, and `busy` stays high throughout.
- R11: `done` is a single-cycle pulse at the end of every command.
- R12: Write-enable and write-disable each send only their opcode byte in one select period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_op | input | 3 | Command code (R2) |
| cmd_addr | input | 16 | Device byte address |
| cmd_cnt | input | LEN_W | Data byte count minus one |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes read byte |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command finished pulse |
| ee_cs_n | output | 1 | Device select, active low |
| ee_sclk | output | 1 | Serial clock |
| ee_sd_o | output | 1 | Data line output value |
| ee_sd_oe | output | 1 | Data line output enable |
| ee_sd_i | input | 1 | Data line input value |

## Verification
A wrong phase or byte counter shows on the data line within one byte time, 16 half periods. It appears as a missing or extra address byte, a shifted opcode, or an output enable that stays on during a returned byte. A broken half-period or select timer shows within a single clock level as a short pulse or a short select gap. A wrong poll decision shows only at the end of a write: the block either finishes while the device still reports busy, or keeps issuing status reads. Counting the status transfers after each write exposes both cases. A stuck read handshake appears the first time the host holds `rd_ready` low.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_WREN  = 3'd2,
    CMD_WRDI  = 3'd3,
    CMD_RDSR  = 3'd4,
    CMD_WRSR  = 3'd5
  } ee_cmd_e;

  typedef enum logic [1:0] {
    PH_OP,
    PH_ADL,
    PH_ADH,
    PH_DAT
  } ee_phase_e;

  localparam logic [7:0] OPC_STAT_RD = 8'h05;
  localparam int unsigned BUSY_BIT = 0;

  function automatic logic [7:0] wire_opcode(ee_cmd_e c);
    case (c)
      CMD_READ:  return 8'h03;
      CMD_WRITE: return 8'h02;
      CMD_WREN:  return 8'h06;
      CMD_WRDI:  return 8'h04;
      CMD_WRSR:  return 8'h01;
      default:   return OPC_STAT_RD;
    endcase
  endfunction

endpackage

// File: rtl/eeprom_delay.sv
module eeprom_delay #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  output logic             fire
);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (load) begin
        cnt_q <= count;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q <= CNT_W'(1)) begin
          run_q <= 1'b0;
          fire  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_bit_eng.sv
module eeprom_bit_eng #(
  parameter int unsigned HALF_CYC = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       drive,
  input  logic       sd_i,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       sd_o,
  output logic       sd_oe
);

  localparam int unsigned TMR_W = $clog2(HALF_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(HALF_CYC - 1);

  logic             active_q;
  logic [3:0]       half_q;
  logic [TMR_W-1:0] tmr_q;
  logic [7:0]       shreg_q;
  logic [3:0]       half_nx;

  assign half_nx = half_q + 4'd1;
  assign rx_byte = shreg_q;

  // One shift register serves both directions: bit 0 leaves on a falling
  // edge, the returned bit enters at bit 7 on the following rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      half_q   <= '0;
      tmr_q    <= '0;
      shreg_q  <= '0;
      sclk     <= 1'b1;
      sd_o     <= 1'b0;
      sd_oe    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active_q) begin
        active_q <= 1'b1;
        half_q   <= '0;
        tmr_q    <= '0;
        shreg_q  <= tx_byte;
        sclk     <= 1'b0;
        sd_o     <= tx_byte[0];
        sd_oe    <= drive;
      end else if (active_q) begin
        if (tmr_q == TMR_END) begin
          tmr_q <= '0;
          if (half_q == 4'd15) begin
            active_q <= 1'b0;
            done     <= 1'b1;
          end else begin
            half_q <= half_nx;
            if (half_nx[0]) begin
              sclk    <= 1'b1;
              shreg_q <= {sd_i, shreg_q[7:1]};
            end else begin
              sclk <= 1'b0;
              sd_o <= shreg_q[0];
            end
          end
        end else begin
          tmr_q <= tmr_q + TMR_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeprom_pkg::*;
#(
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned DLY_W   = 8,
  parameter int unsigned CSS_CYC = 125,
  parameter int unsigned CSH_CYC = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [15:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_cnt,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  output logic             eng_start,
  output logic [7:0]       eng_tx,
  output logic             eng_drive,
  input  logic             eng_done,
  input  logic [7:0]       eng_rx,
  output logic             dly_load,
  output logic [DLY_W-1:0] dly_count,
  input  logic             dly_fire
);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_NEXT, S_SHIFT, S_WRWAIT, S_RDWAIT, S_DESEL
  } seq_state_e;

  seq_state_e       state_q;
  ee_cmd_e          cmd_q;
  ee_phase_e        phase_q;
  logic [15:0]      addr_q;
  logic [LEN_W-1:0] left_q;
  logic             poll_q;
  logic             wip_q;

  logic accept, op_only, is_wr, is_rd, last_byte;
  logic shift_end, rd_end, end_now, need_poll, repoll;

  assign cmd_ready = (state_q == S_IDLE);
  assign busy      = (state_q != S_IDLE);
  assign wr_ready  = (state_q == S_WRWAIT);

  always_comb begin
    accept    = (state_q == S_IDLE) && cmd_valid;
    op_only   = (cmd_q == CMD_WREN) || (cmd_q == CMD_WRDI);
    is_wr     = !poll_q && ((cmd_q == CMD_WRITE) || (cmd_q == CMD_WRSR));
    is_rd     = !poll_q && ((cmd_q == CMD_READ) || (cmd_q == CMD_RDSR));
    last_byte = (cmd_q == CMD_RDSR) || (cmd_q == CMD_WRSR) || (left_q == '0);
    shift_end = (state_q == S_SHIFT) && eng_done &&
                (((phase_q == PH_OP) && !poll_q && op_only) ||
                 ((phase_q == PH_DAT) && (poll_q || (is_wr && last_byte))));
    rd_end    = (state_q == S_RDWAIT) && rd_ready && last_byte;
    end_now   = shift_end || rd_end;
    need_poll = ((cmd_q == CMD_WRITE) || (cmd_q == CMD_WRSR)) && (!poll_q || wip_q);
    repoll    = (state_q == S_DESEL) && dly_fire && need_poll;
    dly_load  = accept || repoll || end_now;
    dly_count = end_now ? DLY_W'(CSH_CYC) : DLY_W'(CSS_CYC);
  end

  always_comb begin
    eng_start = 1'b0;
    eng_tx    = 8'h00;
    eng_drive = 1'b0;
    if (state_q == S_NEXT) begin
      case (phase_q)
        PH_OP: begin
          eng_start = 1'b1;
          eng_drive = 1'b1;
          eng_tx    = poll_q ? OPC_STAT_RD : wire_opcode(cmd_q);
        end
        PH_ADL: begin
          eng_start = 1'b1;
          eng_drive = 1'b1;
          eng_tx    = addr_q[7:0];
        end
        PH_ADH: begin
          eng_start = 1'b1;
          eng_drive = 1'b1;
          eng_tx    = addr_q[15:8];
        end
        default: eng_start = !is_wr;
      endcase
    end else if ((state_q == S_WRWAIT) && wr_valid) begin
      eng_start = 1'b1;
      eng_drive = 1'b1;
      eng_tx    = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      cmd_q    <= CMD_RDSR;
      phase_q  <= PH_OP;
      addr_q   <= '0;
      left_q   <= '0;
      poll_q   <= 1'b0;
      wip_q    <= 1'b0;
      cs_n     <= 1'b1;
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: if (accept) begin
          cmd_q   <= ee_cmd_e'(cmd_op);
          addr_q  <= cmd_addr;
          left_q  <= cmd_cnt;
          poll_q  <= 1'b0;
          wip_q   <= 1'b0;
          phase_q <= PH_OP;
          cs_n    <= 1'b0;
          state_q <= S_SETUP;
        end
        S_SETUP: if (dly_fire) state_q <= S_NEXT;
        S_NEXT: state_q <= ((phase_q == PH_DAT) && is_wr) ? S_WRWAIT : S_SHIFT;
        S_WRWAIT: if (wr_valid) state_q <= S_SHIFT;
        S_SHIFT: if (eng_done) begin
          if (shift_end) begin
            if (poll_q) wip_q <= eng_rx[BUSY_BIT];
            cs_n    <= 1'b1;
            state_q <= S_DESEL;
          end else begin
            state_q <= S_NEXT;
            case (phase_q)
              PH_OP:  phase_q <= (poll_q || (cmd_q == CMD_RDSR) || (cmd_q == CMD_WRSR))
                                 ? PH_DAT : PH_ADL;
              PH_ADL: phase_q <= PH_ADH;
              PH_ADH: phase_q <= PH_DAT;
              default: begin
                if (is_rd) begin
                  rd_data  <= eng_rx;
                  rd_valid <= 1'b1;
                  state_q  <= S_RDWAIT;
                end else begin
                  left_q <= left_q - LEN_W'(1);
                end
              end
            endcase
          end
        end
        S_RDWAIT: if (rd_ready) begin
          rd_valid <= 1'b0;
          if (rd_end) begin
            cs_n    <= 1'b1;
            state_q <= S_DESEL;
          end else begin
            left_q  <= left_q - LEN_W'(1);
            state_q <= S_NEXT;
          end
        end
        S_DESEL: if (dly_fire) begin
          if (need_poll) begin
            poll_q  <= 1'b1;
            phase_q <= PH_OP;
            cs_n    <= 1'b0;
            state_q <= S_SETUP;
          end else begin
            done    <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eeprom_ser_master.sv
module eeprom_ser_master #(
  parameter int unsigned HALF_CYC = 125,
  parameter int unsigned CSS_CYC  = 125,
  parameter int unsigned LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [15:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_cnt,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             ee_cs_n,
  output logic             ee_sclk,
  output logic             ee_sd_o,
  output logic             ee_sd_oe,
  input  logic             ee_sd_i
);

  localparam int unsigned CSH_CYC = 2 * HALF_CYC;
  localparam int unsigned DLY_MAX = (CSS_CYC > CSH_CYC) ? CSS_CYC : CSH_CYC;
  localparam int unsigned DLY_W   = $clog2(DLY_MAX + 1);

  logic             eng_start, eng_drive, eng_done, eng_oe;
  logic [7:0]       eng_tx, eng_rx;
  logic             dly_load, dly_fire;
  logic [DLY_W-1:0] dly_count;

  eeprom_seq #(
    .LEN_W(LEN_W), .DLY_W(DLY_W), .CSS_CYC(CSS_CYC), .CSH_CYC(CSH_CYC)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_cnt(cmd_cnt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .cs_n(ee_cs_n),
    .eng_start(eng_start), .eng_tx(eng_tx), .eng_drive(eng_drive),
    .eng_done(eng_done), .eng_rx(eng_rx),
    .dly_load(dly_load), .dly_count(dly_count), .dly_fire(dly_fire)
  );

  eeprom_bit_eng #(.HALF_CYC(HALF_CYC)) eng_i (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx),
    .drive(eng_drive), .sd_i(ee_sd_i), .done(eng_done), .rx_byte(eng_rx),
    .sclk(ee_sclk), .sd_o(ee_sd_o), .sd_oe(eng_oe)
  );

  eeprom_delay #(.CNT_W(DLY_W)) dly_i (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .count(dly_count), .fire(dly_fire)
  );

  assign ee_sd_oe = eng_oe && !ee_cs_n;

endmodule

// File: rtl/eeprom_ser_master_chk.sv
module eeprom_ser_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       busy,
  input logic       done,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       ee_cs_n,
  input logic       ee_sclk,
  input logic       ee_sd_o,
  input logic       ee_sd_oe
);

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy && !cmd_ready);

  // R4
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs_n |-> ee_sclk);

  // R4
  sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ee_sd_o) |-> $fell(ee_sclk));

  // R6
  oe_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sd_oe |-> !ee_cs_n);

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R7
  rd_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ee_sclk && !ee_cs_n);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind eeprom_ser_master eeprom_ser_master_chk chk_i (.*);

// File: tb/eeprom_ser_master_tb_top.sv
module eeprom_ser_master_tb_top;

  localparam int HALF = 4;
  localparam int CSS  = 6;
  localparam int LW   = 4;
  localparam int C_RD = 0, C_WR = 1, C_WEN = 2, C_WDI = 3, C_SRD = 4, C_SWR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, wr_valid = 1'b0, rd_ready = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [15:0] cmd_addr = '0;
  logic [LW-1:0] cmd_cnt = '0;
  logic [7:0] wr_data = '0;
  logic cmd_ready, wr_ready, rd_valid, busy, done;
  logic [7:0] rd_data;
  logic ee_cs_n, ee_sclk, ee_sd_o, ee_sd_oe;
  logic sd_drv = 1'b0;

  always #2 clk = ~clk;

  eeprom_ser_master #(.HALF_CYC(HALF), .CSS_CYC(CSS), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_cnt(cmd_cnt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .busy(busy), .done(done), .ee_cs_n(ee_cs_n), .ee_sclk(ee_sclk),
    .ee_sd_o(ee_sd_o), .ee_sd_oe(ee_sd_oe), .ee_sd_i(sd_drv)
  );

  int n_run = 0, n_fail = 0, cycles = 0;
  bit timed_out = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural device model ----------------
  logic [7:0] mem[int];
  logic [7:0] wire_log[$], txn_log[$], pend_d[$], rq[$], wq[$], expq[$];
  int bcnt = 0, adr = 0, wip_left = 0, err_dir = 0;
  logic [7:0] sh = '0, op = '0, sr_new = '0;
  logic [5:0] sr_hi = '0;
  bit wel = 0, sr_got = 0, in_txn = 0;

  function automatic logic [7:0] mem_rd(int a);
    int k = a & 16'hFFFF;
    if (mem.exists(k)) return mem[k];
    return 8'((k * 7) + 3);
  endfunction

  always @(negedge ee_cs_n) begin
    bcnt = 0; pend_d.delete(); sr_got = 0; op = 8'h00; in_txn = 1;
  end

  always @(posedge ee_sclk) if (ee_cs_n === 1'b0) begin
    int idx;
    bit exp_oe;
    idx = bcnt / 8;
    exp_oe = (idx == 0) || ((op == 8'h03 || op == 8'h02) && idx <= 2) ||
             op == 8'h02 || op == 8'h01;
    if (ee_sd_oe !== exp_oe) err_dir++;
    sh = {ee_sd_o, sh[7:1]};
    bcnt++;
    if (bcnt % 8 == 0) begin
      if (exp_oe) wire_log.push_back(sh);
      if (idx == 0) op = sh;
      else if (idx == 1) begin adr = int'(sh); sr_new = sh; sr_got = 1; end
      else if (idx == 2) adr = adr | (int'(sh) << 8);
      else if (op == 8'h02) pend_d.push_back(sh);
    end
  end

  always @(negedge ee_sclk) if (ee_cs_n === 1'b0 && bcnt >= 8) begin
    int idx;
    logic [7:0] t;
    idx = bcnt / 8;
    t = 8'h00;
    if (op == 8'h03 && idx >= 3) t = mem_rd(adr + idx - 3);
    else if (op == 8'h05) t = {sr_hi, wel, wip_left > 0};
    sd_drv = t[bcnt % 8];
  end

  always @(posedge ee_cs_n) if (in_txn) begin
    in_txn = 0;
    txn_log.push_back(op);
    case (op)
      8'h06: wel = 1;
      8'h04: wel = 0;
      8'h02: if (wel && pend_d.size() > 0) begin
        foreach (pend_d[i]) mem[(adr + i) & 16'hFFFF] = pend_d[i];
        wel = 0; wip_left = 2;
      end
      8'h01: if (wel && sr_got) begin
        sr_hi = sr_new[7:2]; wel = 0; wip_left = 2;
      end
      8'h05: if (wip_left > 0) wip_left--;
      default: ;
    endcase
  end

  // ---------------- per-clock protocol reference ----------------
  logic p_cs = 1, p_sclk = 1, p_sd = 0;
  int run = 0, css_run = 0, hi_run = 0;
  bit want_rise = 0, had_txn = 0;
  int err_idle = 0, err_sd = 0, err_half = 0, err_css = 0, err_csh = 0, err_oe = 0, err_rdy = 0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) timed_out = 1;
    if (rst_n) begin
      if (ee_cs_n && !ee_sclk) err_idle++;
      if (ee_cs_n && ee_sd_oe) err_oe++;
      if (ee_sd_o != p_sd && !(p_sclk && !ee_sclk)) err_sd++;
      if (cmd_ready == busy) err_rdy++;
      if (!ee_cs_n) begin
        if (p_cs) begin
          if (had_txn && hi_run < 2 * HALF) err_csh++;
          css_run = 0; want_rise = 1; run = 1000; had_txn = 1;
        end
        if (ee_sclk != p_sclk) begin
          if (run < HALF) err_half++;
          run = 1;
        end else run++;
        if (want_rise && ee_sclk && !p_sclk) begin
          if (css_run < CSS) err_css++;
          want_rise = 0;
        end
        css_run++;
      end else hi_run = p_cs ? hi_run + 1 : 1;
      p_cs = ee_cs_n; p_sclk = ee_sclk; p_sd = ee_sd_o;
    end
  end

  // ---------------- host driver ----------------
  int busy_drop = 0, extra_done = 0, polls = 0;

  task automatic run_cmd(int opc, int addr, int cnt, int wgap, int rstall);
    int gap, spin;
    bit got, wfire;
    rq.delete(); wire_log.delete(); txn_log.delete();
    busy_drop = 0; extra_done = 0;
    @(negedge clk);
    while (!cmd_ready && !timed_out) @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(opc); cmd_addr = 16'(addr); cmd_cnt = LW'(cnt);
    @(negedge clk);
    cmd_valid = 0;
    gap = wgap; spin = 0; got = 0; wfire = 0;
    while (!got && !timed_out) begin
      if (done) got = 1;
      else if (!busy) busy_drop++;
      if (wfire) begin void'(wq.pop_front()); wr_valid = 0; gap = wgap; end
      rd_ready = (rstall == 0) || (spin % rstall == 0);
      if (rd_valid && rd_ready) rq.push_back(rd_data);
      if (!wr_valid && wq.size() > 0) begin
        if (gap > 0) gap--;
        else begin wr_valid = 1; wr_data = wq[0]; end
      end
      wfire = wr_valid && wr_ready;
      spin++;
      @(negedge clk);
    end
    rd_ready = 0;
    for (int i = 0; i < 4; i++) begin
      if (done) extra_done++;
      @(negedge clk);
    end
    polls = 0;
    foreach (txn_log[i]) if (i > 0 && txn_log[i] == 8'h05) polls++;
  endtask

  task automatic cmp_q(string req, string what, logic [7:0] got_q[$]);
    int bad = -1;
    if (got_q.size() != expq.size()) bad = 999;
    else foreach (expq[i]) if (bad < 0 && got_q[i] !== expq[i]) bad = i;
    if (bad == 999) chk(0, req, {what, " length"}, got_q.size(), expq.size());
    else if (bad >= 0) chk(0, req, what, got_q[bad], expq[bad]);
    else chk(1, req, what, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R4 R6: reset state
    chk(cmd_ready && !busy, "R1", "idle after reset", {cmd_ready, busy}, 2'b10);
    chk(ee_cs_n && ee_sclk && !ee_sd_oe, "R4", "pins after reset",
        {ee_cs_n, ee_sclk, ee_sd_oe}, 3'b110);

    // R12 R2: write-enable is a lone opcode byte
    run_cmd(C_WEN, 0, 0, 0, 0);
    expq = '{8'h06};
    cmp_q("R12", "write-enable wire bytes", wire_log);
    chk(txn_log.size() == 1, "R12", "write-enable transfers", txn_log.size(), 1);
    chk(extra_done == 0 && busy_drop == 0, "R11", "single done pulse", extra_done, 0);

    // R9: status read sees latch set
    run_cmd(C_SRD, 0, 0, 0, 0);
    expq = '{8'h02};
    cmp_q("R9", "status after enable", rq);

    // R8 R3 R10: paced write of three bytes
    wq = '{8'hA1, 8'h3C, 8'hF0};
    run_cmd(C_WR, 16'h1234, 2, 7, 0);
    expq = '{8'h02, 8'h34, 8'h12, 8'hA1, 8'h3C, 8'hF0, 8'h05, 8'h05, 8'h05};
    cmp_q("R3", "write wire bytes lsb first", wire_log);
    chk(polls == 3, "R10", "status polls after write", polls, 3);
    chk(rq.size() == 0, "R10", "polls hidden from read stream", rq.size(), 0);
    chk(busy_drop == 0, "R10", "busy through polling", busy_drop, 0);

    // R7: read back with host back-pressure
    run_cmd(C_RD, 16'h1234, 2, 0, 5);
    expq = '{8'hA1, 8'h3C, 8'hF0};
    cmp_q("R7", "read data", rq);
    expq = '{8'h03, 8'h34, 8'h12};
    cmp_q("R2", "read opcode and address", wire_log);

    // R7 R3: read across a 256-byte boundary of unwritten cells
    run_cmd(C_RD, 16'h00FF, 1, 0, 0);
    expq = '{mem_rd(16'h00FF), mem_rd(16'h0100)};
    cmp_q("R7", "boundary read data", rq);
    expq = '{8'h03, 8'hFF, 8'h00};
    cmp_q("R3", "boundary address bytes", wire_log);

    // R12 R9: disable clears latch
    run_cmd(C_WDI, 0, 0, 0, 0);
    expq = '{8'h04};
    cmp_q("R12", "write-disable wire bytes", wire_log);
    run_cmd(C_SRD, 0, 0, 0, 3);
    expq = '{8'h00};
    cmp_q("R9", "status after disable", rq);

    // R9 R10: status write
    run_cmd(C_WEN, 0, 0, 0, 0);
    wq = '{8'h8C};
    run_cmd(C_SWR, 0, 0, 2, 0);
    expq = '{8'h01, 8'h8C, 8'h05, 8'h05, 8'h05};
    cmp_q("R9", "status write wire bytes", wire_log);
    run_cmd(C_SRD, 0, 0, 0, 0);
    expq = '{8'h8C};
    cmp_q("R9", "status write readback", rq);

    // R10: write without latch polls once and leaves memory alone
    wq = '{8'h55};
    run_cmd(C_WR, 16'h1234, 0, 0, 0);
    chk(polls == 1, "R10", "single poll when device idle", polls, 1);
    run_cmd(C_RD, 16'h1234, 0, 0, 0);
    expq = '{8'hA1};
    cmp_q("R7", "unlatched write ignored", rq);

    // R4 R5 R6 R1: per-clock reference counters
    chk(err_idle == 0 && err_sd == 0, "R4", "mode 3 edges", err_idle + err_sd, 0);
    chk(err_half == 0, "R5", "half period", err_half, 0);
    chk(err_css == 0, "R5", "select to first rise", err_css, 0);
    chk(err_csh == 0, "R5", "select high gap", err_csh, 0);
    chk(err_oe == 0 && err_dir == 0, "R6", "data line direction", err_oe + err_dir, 0);
    chk(err_rdy == 0, "R1", "ready versus busy", err_rdy, 0);

    if (timed_out) chk(0, "R1", "watchdog expired", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule